// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is one output cell of a small programmable logic device. An external AND array supplies eight product terms. The cell ORs them, applies a selectable polarity, and then either registers the result on the rising clock or passes it straight through. It produces an output value and an output-buffer enable, plus a feedback bit that returns to the AND array.

Two global mode bits and one per-cell mode bit reconfigure the cell into one of four roles: registered output, dedicated combinational output, combinational I/O, or input only. In the combinational I/O role the last product term stops contributing to the sum and instead gates the output buffer. The buffer enable is a plain logic output, and the actual tri-state driver sits outside the block. The resolved pin level comes back on `pin_in` so that the pin can act as an input whenever the buffer is off.

Top module: `plm_macrocell`

## Requirements
- R1: Mode decode on (`glob_a`,`glob_b`,`cell_cfg`) is as follows. 0,1,0 is registered. 1,0,0 is combinational output. 0,1,1 and 1,1,1 are combinational I/O. 1,0,1 is input only. 0,0,0, 0,0,1 and 1,1,0 are unused.
- R2: In registered mode, the OR of all eight terms (polarity applied) is captured on the rising clock. `data_out` shows it after that edge and holds steady between edges.
- R3: In registered mode, `buf_en` equals the inverse of `oe_pin_n`, and `fb_out` equals the register output.
- R4: With `cell_inv`=1 the OR result is inverted, both in the registered path and in the combinational path. With `cell_inv`=0 it passes unchanged.
- R5: In combinational output mode, `data_out` is the OR of all eight terms in the same cycle. `buf_en`=1 and `fb_out` equals `data_out`.
- R6: In combinational I/O mode, only terms 0 to 6 are ORed. Term 7 has no effect on `data_out`.
- R7: In combinational I/O mode, `buf_en` equals term 7 and `fb_out` equals `pin_in`.
- R8: In input-only mode, `buf_en`=0, `data_out`=0 and `fb_out` equals `pin_in`.
- R9: Unused mode codes force `buf_en`=0, `data_out`=0 and `fb_out`=0.
- R10: A low `rst_n` at a rising edge clears the register to 0.
- R11: Outside registered mode, `oe_pin_n` has no effect on `buf_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the register |
| pterm | input | N_TERMS | Product terms from the AND array |
| glob_a | input | 1 | First global mode bit |
| glob_b | input | 1 | Second global mode bit |
| cell_cfg | input | 1 | Per-cell mode bit |
| cell_inv | input | 1 | Per-cell polarity: 1 inverts the sum |
| oe_pin_n | input | 1 | Device output-enable pin, active low |
| pin_in | input | 1 | Resolved level at the cell's I/O pin |
| data_out | output | 1 | Value the output buffer drives |
| buf_en | output | 1 | Output-buffer enable |
| fb_out | output | 1 | Feedback bit to the AND array |

## Verification
The results follow two timings:
- **Combinational modes:** the output, enable and feedback respond within the same cycle as the stimulus.
- **Registered mode:** the output and feedback change only at the first rising edge after the stimulus.

The bench drives each stimulus on the falling edge and queues its expected result. It then checks that result a quarter period after the next rising edge, which is the earliest point at which both kinds of result are settled. For the registered path, one extra check just after the stimulus confirms that the output still holds the earlier value before the edge arrives.

// File: rtl/plm_pkg.sv
// Shared types for the programmable-logic output cell.
// Assumes the three mode bits are static or change only between clock edges.
package plm_pkg;

    typedef enum logic [2:0] {
        CM_REGISTERED,
        CM_COMB_OUT,
        CM_COMB_IO,
        CM_INPUT_ONLY,
        CM_UNUSED
    } cell_mode_e;

    typedef struct packed {
        cell_mode_e mode;
        logic       reserve_last;   // last term leaves the OR sum
        logic       en_from_term;   // buffer enable comes from the last term
    } cell_ctrl_t;

    // Maps the global pair plus the cell bit onto a role (R1 encoding).
    function automatic cell_ctrl_t decode_mode(input logic ga, input logic gb, input logic cs);
        cell_ctrl_t c;
        c.reserve_last = 1'b0;
        c.en_from_term = 1'b0;
        unique case ({ga, gb, cs})
            3'b010:          c.mode = CM_REGISTERED;
            3'b100:          c.mode = CM_COMB_OUT;
            3'b011, 3'b111: begin
                c.mode         = CM_COMB_IO;
                c.reserve_last = 1'b1;
                c.en_from_term = 1'b1;
            end
            3'b101:          c.mode = CM_INPUT_ONLY;
            default:         c.mode = CM_UNUSED;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/plm_mode_decode.sv
// Turns the three mode bits into a role plus steering flags.
// Purely combinational; it assumes the mode bits come from stable configuration.
module plm_mode_decode
    import plm_pkg::*;
(
    input  logic       glob_a,
    input  logic       glob_b,
    input  logic       cell_cfg,
    output cell_ctrl_t ctrl
);

    // Decode the mode bits through the shared table.
    always_comb begin
        ctrl = decode_mode(glob_a, glob_b, cell_cfg);
    end

endmodule

// File: rtl/plm_term_sum.sv
// ORs the product terms through a prefix chain. It offers the full sum and
// the sum without the last term, for the modes that reserve that term.
// Assumes N_TERMS >= 2.
module plm_term_sum #(
    parameter int N_TERMS = 8
) (
    input  logic [N_TERMS-1:0] pterm,
    output logic               sum_all,
    output logic               sum_less
);

    localparam int LAST = N_TERMS - 1;

    logic [N_TERMS-1:0] acc;

    assign acc[0] = pterm[0];

    // Build the running OR so that both sums come from one chain.
    for (genvar i = 1; i < N_TERMS; i++) begin : g_prefix
        assign acc[i] = acc[i-1] | pterm[i];
    end

    assign sum_all  = acc[LAST];
    assign sum_less = acc[LAST-1];

endmodule

// File: rtl/plm_out_reg.sv
// The cell's single flip-flop. It loads on every rising edge and clears
// synchronously while rst_n is low. Assumes clk is free-running.
module plm_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    // Capture the polarity-adjusted sum, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end

endmodule

// File: rtl/plm_macrocell.sv
// One configurable output cell. It sums product terms, applies polarity,
// and either registers the result or passes it through. It also steers the
// buffer enable and the feedback according to the decoded role.
// Assumes the tri-state driver is outside and its resolved level returns on pin_in.
module plm_macrocell
    import plm_pkg::*;
#(
    parameter int N_TERMS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TERMS-1:0] pterm,
    input  logic               glob_a,
    input  logic               glob_b,
    input  logic               cell_cfg,
    input  logic               cell_inv,
    input  logic               oe_pin_n,
    input  logic               pin_in,
    output logic               data_out,
    output logic               buf_en,
    output logic               fb_out
);

    localparam int LAST = N_TERMS - 1;

    cell_ctrl_t ctrl;
    logic       sum_all;
    logic       sum_less;
    logic       sum_sel;
    logic       comb_val;
    logic       reg_d;
    logic       reg_q;

    plm_mode_decode u_decode (
        .glob_a   (glob_a),
        .glob_b   (glob_b),
        .cell_cfg (cell_cfg),
        .ctrl     (ctrl)
    );

    plm_term_sum #(.N_TERMS(N_TERMS)) u_sum (
        .pterm    (pterm),
        .sum_all  (sum_all),
        .sum_less (sum_less)
    );

    // Pick the sum width for the role, then apply the cell polarity.
    always_comb begin
        sum_sel  = ctrl.reserve_last ? sum_less : sum_all;
        comb_val = sum_sel ^ cell_inv;
        reg_d    = sum_all ^ cell_inv;
    end

    plm_out_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (reg_d),
        .q     (reg_q)
    );

    // Steer the output value, buffer enable and feedback for the decoded role.
    always_comb begin
        data_out = 1'b0;
        buf_en   = 1'b0;
        fb_out   = 1'b0;
        case (ctrl.mode)
            CM_REGISTERED: begin
                data_out = reg_q;
                buf_en   = ~oe_pin_n;
                fb_out   = reg_q;
            end
            CM_COMB_OUT: begin
                data_out = comb_val;
                buf_en   = 1'b1;
                fb_out   = comb_val;
            end
            CM_COMB_IO: begin
                data_out = comb_val;
                buf_en   = ctrl.en_from_term & pterm[LAST];
                fb_out   = pin_in;
            end
            CM_INPUT_ONLY: begin
                fb_out   = pin_in;
            end
            default: begin
                data_out = 1'b0;
            end
        endcase
    end

    // Mode flags derived straight from the ports, for the checks below.
    logic chk_reg, chk_io, chk_in, chk_unused;
    assign chk_reg    = !glob_a &&  glob_b && !cell_cfg;
    assign chk_io     =  glob_b &&  cell_cfg;
    assign chk_in     =  glob_a && !glob_b &&  cell_cfg;
    assign chk_unused = (!glob_a && !glob_b) || (glob_a && glob_b && !cell_cfg);

    // R2: the registered output shows the sum present before the last edge.
    assert_reg_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_reg && $past(rst_n)) |-> (data_out == $past((|pterm) ^ cell_inv)));

    // R3: the device pin gates the buffer, and feedback tracks the register.
    assert_reg_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_reg |-> (buf_en == !oe_pin_n && fb_out == data_out));

    // R7: the last term gates the buffer and feedback follows the pin.
    assert_io_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_io |-> (buf_en == pterm[LAST] && fb_out == pin_in));

    // R8: input-only mode never enables the buffer.
    assert_input_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_in |-> (!buf_en && fb_out == pin_in));

    // R9: unused codes give a silent cell.
    assert_unused_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_unused |-> (!buf_en && !data_out && !fb_out));

    // R10: the cycle after a reset edge in registered mode shows zero.
    assert_reset_clear_R10: assert property (@(posedge clk)
        (rst_n && $past(rst_n) == 1'b0 && chk_reg) |-> (data_out == 1'b0));

endmodule

// File: tb/tb_plm_macrocell.sv
// Scoreboard bench: the driver applies a stimulus on the falling edge and
// queues the expected triple; the monitor checks it after the next rising edge.
module tb_plm_macrocell;

    localparam int CLK_PERIOD = 10;
    localparam int N_TERMS    = 8;

    typedef struct {
        string tag;
        logic  e_out;
        logic  e_en;
        logic  e_fb;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [N_TERMS-1:0] pterm;
    logic               glob_a, glob_b, cell_cfg, cell_inv, oe_pin_n;
    logic               ext_drv;
    logic               pin_in;
    logic               data_out, buf_en, fb_out;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];
    logic last_out;
    bit   last_reg = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Resolve the pin: the cell drives it when enabled, else the outside driver does.
    assign pin_in = buf_en ? data_out : ext_drv;

    plm_macrocell #(.N_TERMS(N_TERMS)) dut (
        .clk(clk), .rst_n(rst_n), .pterm(pterm),
        .glob_a(glob_a), .glob_b(glob_b), .cell_cfg(cell_cfg),
        .cell_inv(cell_inv), .oe_pin_n(oe_pin_n), .pin_in(pin_in),
        .data_out(data_out), .buf_en(buf_en), .fb_out(fb_out)
    );

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    // Apply one stimulus, predict the result from the requirements, and queue it.
    task automatic apply(input string tag, input logic rs, input logic [N_TERMS-1:0] pt,
                         input logic [2:0] mode, input logic inv, input logic oen,
                         input logic ext);
        exp_t e;
        logic all_s, less_s;
        bit   is_reg;
        @(negedge clk);
        rst_n = rs; pterm = pt; {glob_a, glob_b, cell_cfg} = mode;
        cell_inv = inv; oe_pin_n = oen; ext_drv = ext;
        all_s  = |pt;
        less_s = |pt[N_TERMS-2:0];
        is_reg = (mode == 3'b010);
        e.tag  = tag;
        case (mode)
            3'b010: begin e.e_out = rs ? (all_s ^ inv) : 1'b0; e.e_en = ~oen; e.e_fb = e.e_out; end
            3'b100: begin e.e_out = all_s ^ inv; e.e_en = 1'b1; e.e_fb = e.e_out; end
            3'b011, 3'b111: begin
                e.e_out = less_s ^ inv; e.e_en = pt[N_TERMS-1];
                e.e_fb  = e.e_en ? e.e_out : ext;
            end
            3'b101: begin e.e_out = 1'b0; e.e_en = 1'b0; e.e_fb = ext; end
            default: begin e.e_out = 1'b0; e.e_en = 1'b0; e.e_fb = 1'b0; end
        endcase
        // R2: before the edge, a registered output still holds its old value.
        if (is_reg && last_reg && rs) begin
            #1;
            check1({tag, " R2 hold"}, "data_out", data_out, last_out);
        end
        last_reg = is_reg && rs;
        last_out = e.e_out;
        sb_q.push_back(e);
    endtask

    // Monitor: pop and compare one expected item after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check1(e.tag, "data_out", data_out, e.e_out);
                check1(e.tag, "buf_en",   buf_en,   e.e_en);
                check1(e.tag, "fb_out",   fb_out,   e.e_fb);
            end
        end
    end

    // Driver sequence.
    initial begin
        rst_n = 1'b0; pterm = '0; glob_a = 0; glob_b = 1; cell_cfg = 0;
        cell_inv = 0; oe_pin_n = 0; ext_drv = 0;
        // R10 reset clears the register even with all terms high.
        apply("R10 reset",         1'b0, 8'hFF, 3'b010, 0, 0, 0);
        // R1 R2 registered capture of all eight terms
        apply("R1 R2 reg zero",    1'b1, 8'h00, 3'b010, 0, 0, 0);
        apply("R2 reg term0",      1'b1, 8'h01, 3'b010, 0, 0, 0);
        apply("R2 reg drop",       1'b1, 8'h00, 3'b010, 0, 0, 0);
        apply("R2 reg term7",      1'b1, 8'h80, 3'b010, 0, 0, 0);
        apply("R4 reg invert",     1'b1, 8'h00, 3'b010, 1, 0, 0);
        apply("R4 reg invert hi",  1'b1, 8'h24, 3'b010, 1, 0, 1);
        apply("R3 reg oe off",     1'b1, 8'h10, 3'b010, 0, 1, 1);
        // R5 dedicated combinational output
        apply("R5 comb zero",      1'b1, 8'h00, 3'b100, 0, 0, 0);
        apply("R5 comb term6",     1'b1, 8'h40, 3'b100, 0, 0, 1);
        apply("R5 comb term7",     1'b1, 8'h80, 3'b100, 0, 0, 0);
        apply("R4 comb invert",    1'b1, 8'h00, 3'b100, 1, 0, 0);
        apply("R11 comb oe pin",   1'b1, 8'h02, 3'b100, 0, 1, 0);
        // R6 R7 combinational I/O, both codes
        apply("R6 io term7 only",  1'b1, 8'h80, 3'b011, 0, 0, 1);
        apply("R7 io off drv0",    1'b1, 8'h01, 3'b011, 0, 0, 0);
        apply("R7 io on",          1'b1, 8'h81, 3'b011, 0, 0, 0);
        apply("R7 io pin input",   1'b1, 8'h00, 3'b011, 0, 0, 1);
        apply("R6 io alt code",    1'b1, 8'h82, 3'b111, 1, 0, 1);
        apply("R11 io oe pin",     1'b1, 8'h04, 3'b111, 0, 1, 1);
        // R8 input only
        apply("R8 input hi",       1'b1, 8'hFF, 3'b101, 0, 0, 1);
        apply("R8 input lo",       1'b1, 8'hFF, 3'b101, 1, 1, 0);
        // R9 unused codes
        apply("R9 code000",        1'b1, 8'hFF, 3'b000, 1, 0, 1);
        apply("R9 code001",        1'b1, 8'hFF, 3'b001, 0, 0, 1);
        apply("R9 code110",        1'b1, 8'hFF, 3'b110, 1, 0, 1);
        // R2 back to registered after other modes
        apply("R2 reg return",     1'b1, 8'h08, 3'b010, 0, 0, 0);
        apply("R2 reg return low", 1'b1, 8'h00, 3'b010, 0, 0, 0);
        repeat (3) @(posedge clk);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule